// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This block is the front end of a parallel decimal multiplier. It takes an N-digit BCD multiplicand and an N-digit BCD multiplier and produces every partial product at once, so that a later carry-save tree and adder can form the 2N-digit product. Each multiplier digit is recoded into a signed digit between -5 and +5. The recoding uses a carry: a digit (plus incoming carry) above five becomes a negative selection and passes +1 to the next digit. As a result, only the 1x to 5x multiples of the multiplicand have to exist. When the top digit produces such a carry, one extra partial product equal to the multiplicand, weighted by 10^N, corrects the sum.

All partial products leave the block in BCD-4221, shifted to their digit weight inside a common field of 2N+1 digits. Negative ones are sent as a nines' complement. A separate hot-one bit completes each of them to a tens' complement. The outputs are registered once, and a new operand pair is accepted on every cycle.

Top module: `sd_decimal_pp_gen`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle, and every output is cleared one cycle after a cycle with `rst` high.
- R2: The sum of all rows `pp[0..N]`, plus `hot_ones[i]`·10^i for each i, equals A·B modulo 10^(2N+1).
- R3: Multiplier digit i is recoded with carry: e = b_i + c_i, with c_0 = 0. If e ≤ 5, the selection is +e and the outgoing carry is 0. If e ≥ 6, the selection is −(10−e) and the outgoing carry is 1. For e = 10 the selection is zero.
- R4: Each 4-bit digit of every row is BCD-4221: bits 3, 2, 1, 0 weigh 4, 2, 2, 1. A negative row fills every digit above its multiple with 4'b1111 (value 9). A positive row fills those digits with 4'b0000.
- R5: A positive selection m in row i has value m·A·10^i. A negative selection m has value 10^(2N+1) − (m·A+1)·10^i. Digits below position i are zero.
- R6: A zero selection gives a row of all zero bits.
- R7: `pp_en[N]` is the carry out of the top multiplier digit. Row N then holds A·10^N; otherwise row N is zero.
- R8: `hot_ones[i]` is 1 exactly when row i holds a negative, non-zero selection.
- R9: `pp_en[i]` (i < N) is 1 exactly when the selection of digit i is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| a_bcd | input | 4N | Multiplicand, BCD-8421, digit 0 in bits 3:0 |
| b_bcd | input | 4N | Multiplier, BCD-8421, digit 0 in bits 3:0 |
| out_valid | output | 1 | Partial products are valid |
| pp | output | (N+1)·4(2N+1) | Rows 0..N, BCD-4221, aligned to digit weight |
| pp_en | output | N+1 | Row carries a non-zero term |
| hot_ones | output | N | +10^i completion for negative row i |

## Verification
The hardest situation to reach is a carry chain that crosses several digits. In such a chain a digit of 5 turns negative only because its lower neighbour carried into it. A 9 followed by a carry lands on e = 10, which is a zero selection that still carries. The chain may run out of the top digit into the corrective row. A three-digit configuration is swept over all 1000 multiplier values for a spread of multiplicands. Every chain of 5s, 9s and mixed digits, and every carry out of the top, is therefore driven. Each row is checked on its own, and the sum of the rows is checked against the integer product.

// File: rtl/sdpp_pkg.sv
package sdpp_pkg;

    // one recoded multiplier digit: sign and magnitude 0..5
    typedef struct packed {
        logic       neg;
        logic [2:0] mag;
    } sdig_t;

    // BCD value 0..9 to a 4221 code (weights 4,2,2,1)
    function automatic logic [3:0] enc4221(input logic [3:0] v);
        logic [3:0] c;
        case (v)
            4'd0: c = 4'b0000;
            4'd1: c = 4'b0001;
            4'd2: c = 4'b0010;
            4'd3: c = 4'b0011;
            4'd4: c = 4'b1000;
            4'd5: c = 4'b1001;
            4'd6: c = 4'b1010;
            4'd7: c = 4'b1011;
            4'd8: c = 4'b1110;
            4'd9: c = 4'b1111;
            default: c = 4'b0000;
        endcase
        return c;
    endfunction

    // low digit of 2*d plus the carry from the neighbour below
    function automatic logic [3:0] dbl_digit(input logic [3:0] d, input logic cin);
        logic [4:0] t;
        t = {d, 1'b0};
        if (t >= 5'd10) t = t - 5'd10;
        return t[3:0] + {3'b000, cin};
    endfunction

    // digit of 5*A: 5 if own digit odd, plus half of the digit below
    function automatic logic [3:0] quint_digit(input logic [3:0] d, input logic [3:0] below);
        return (d[0] ? 4'd5 : 4'd0) + {1'b0, below[3:1]};
    endfunction

endpackage

// File: rtl/sdpp_multiples.sv
module sdpp_multiples #(
    parameter int N = 16
) (
    input  logic [4*N-1:0]           a_bcd,
    output logic [5:1][4*(N+1)-1:0]  mult
);
    import sdpp_pkg::*;

    localparam int MW = N + 1;

    logic [MW-1:0][3:0] ad;
    logic [MW-1:0][3:0] m2;
    logic [MW-1:0][3:0] m3;
    logic [MW-1:0][3:0] m4;
    logic [MW-1:0][3:0] m5;

    for (genvar j = 0; j < MW; j++) begin : g_dig
        if (j < N) begin : g_in
            assign ad[j] = a_bcd[4*j +: 4];
        end else begin : g_pad
            assign ad[j] = 4'd0;
        end

        if (j == 0) begin : g_lsd
            assign m2[j] = dbl_digit(ad[j], 1'b0);
            assign m4[j] = dbl_digit(m2[j], 1'b0);
            assign m5[j] = quint_digit(ad[j], 4'd0);
        end else begin : g_up
            assign m2[j] = dbl_digit(ad[j], ad[j-1] >= 4'd5);
            assign m4[j] = dbl_digit(m2[j], m2[j-1] >= 4'd5);
            assign m5[j] = quint_digit(ad[j], ad[j-1]);
        end

        assign mult[1][4*j +: 4] = enc4221(ad[j]);
        assign mult[2][4*j +: 4] = enc4221(m2[j]);
        assign mult[3][4*j +: 4] = enc4221(m3[j]);
        assign mult[4][4*j +: 4] = enc4221(m4[j]);
        assign mult[5][4*j +: 4] = enc4221(m5[j]);
    end

    // 3x = 1x + 2x, decimal ripple addition
    always_comb begin
        logic       cy;
        logic [4:0] s;
        cy = 1'b0;
        for (int j = 0; j < MW; j++) begin
            s = {1'b0, ad[j]} + {1'b0, m2[j]} + {4'b0000, cy};
            if (s >= 5'd10) begin
                m3[j] = 4'(s - 5'd10);
                cy    = 1'b1;
            end else begin
                m3[j] = s[3:0];
                cy    = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdpp_recoder.sv
module sdpp_recoder #(
    parameter int N = 16
) (
    input  logic [4*N-1:0]        b_bcd,
    output sdpp_pkg::sdig_t [N-1:0] sel,
    output logic                  corr
);
    always_comb begin
        logic       cy;
        logic [3:0] e;
        cy = 1'b0;
        for (int i = 0; i < N; i++) begin
            e = b_bcd[4*i +: 4] + {3'b000, cy};
            if (e > 4'd5) begin
                sel[i].neg = (e != 4'd10);
                sel[i].mag = 3'(4'd10 - e);
                cy         = 1'b1;
            end else begin
                sel[i].neg = 1'b0;
                sel[i].mag = e[2:0];
                cy         = 1'b0;
            end
        end
        corr = cy;
    end

endmodule

// File: rtl/sdpp_row_select.sv
module sdpp_row_select #(
    parameter int N   = 16,
    parameter int POS = 0
) (
    input  logic [5:1][4*(N+1)-1:0] mult,
    input  sdpp_pkg::sdig_t         sel,
    output logic [4*(2*N+1)-1:0]    row,
    output logic                    hot,
    output logic                    en
);
    localparam int W  = 2*N + 1;
    localparam int MW = N + 1;

    logic [4*MW-1:0] pick;

    always_comb begin
        case (sel.mag)
            3'd1:    pick = mult[1];
            3'd2:    pick = mult[2];
            3'd3:    pick = mult[3];
            3'd4:    pick = mult[4];
            3'd5:    pick = mult[5];
            default: pick = '0;
        endcase
    end

    assign en  = (sel.mag != 3'd0) && (sel.mag <= 3'd5);
    assign hot = en && sel.neg;

    for (genvar k = 0; k < W; k++) begin : g_col
        if (k < POS) begin : g_low
            assign row[4*k +: 4] = 4'b0000;
        end else if (k < POS + MW) begin : g_body
            assign row[4*k +: 4] = !en     ? 4'b0000 :
                                   sel.neg ? ~pick[4*(k-POS) +: 4] :
                                              pick[4*(k-POS) +: 4];
        end else begin : g_ext
            assign row[4*k +: 4] = hot ? 4'b1111 : 4'b0000;
        end
    end

endmodule

// File: rtl/sd_decimal_pp_gen.sv
module sd_decimal_pp_gen #(
    parameter int N = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [4*N-1:0]                a_bcd,
    input  logic [4*N-1:0]                b_bcd,
    output logic                          out_valid,
    output logic [N:0][4*(2*N+1)-1:0]     pp,
    output logic [N:0]                    pp_en,
    output logic [N-1:0]                  hot_ones
);
    import sdpp_pkg::*;

    localparam int W = 2*N + 1;

    logic [5:1][4*(N+1)-1:0]   mult;
    sdig_t [N-1:0]             sel;
    logic                      corr;
    logic [N:0][4*W-1:0]       pp_c;
    logic [N:0]                en_c;
    logic [N-1:0]              hot_c;

    sdpp_multiples #(.N(N)) u_mult (
        .a_bcd (a_bcd),
        .mult  (mult)
    );

    sdpp_recoder #(.N(N)) u_rec (
        .b_bcd (b_bcd),
        .sel   (sel),
        .corr  (corr)
    );

    for (genvar i = 0; i < N; i++) begin : g_row
        sdpp_row_select #(.N(N), .POS(i)) u_sel (
            .mult (mult),
            .sel  (sel[i]),
            .row  (pp_c[i]),
            .hot  (hot_c[i]),
            .en   (en_c[i])
        );
    end

    // corrective row: 1x weighted by 10^N
    for (genvar k = 0; k < W; k++) begin : g_corr
        if (k < N) begin : g_low
            assign pp_c[N][4*k +: 4] = 4'b0000;
        end else begin : g_body
            assign pp_c[N][4*k +: 4] = corr ? mult[1][4*(k-N) +: 4] : 4'b0000;
        end
    end
    assign en_c[N] = corr;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pp        <= '0;
            pp_en     <= '0;
            hot_ones  <= '0;
        end else begin
            out_valid <= in_valid;
            pp        <= pp_c;
            pp_en     <= en_c;
            hot_ones  <= hot_c;
        end
    end

endmodule

// File: rtl/sdpp_checker.sv
module sdpp_checker #(
    parameter int N = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [3:0]                b_top,
    input logic                      out_valid,
    input logic [N:0][4*(2*N+1)-1:0] pp,
    input logic [N:0]                pp_en,
    input logic [N-1:0]              hot_ones
);
    localparam int W = 2*N + 1;

    logic bad_zero, bad_low, bad_ext;

    always_comb begin
        bad_zero = 1'b0;
        bad_low  = 1'b0;
        bad_ext  = 1'b0;
        for (int r = 0; r <= N; r++)
            if (!pp_en[r] && (pp[r] != '0)) bad_zero = 1'b1;
        for (int r = 0; r < N; r++) begin
            for (int k = 0; k < N; k++)
                if (k < r && pp[r][4*k +: 4] != 4'b0000) bad_low = 1'b1;
            if (pp_en[r] && pp[r][4*(W-1) +: 4] != (hot_ones[r] ? 4'b1111 : 4'b0000))
                bad_ext = 1'b1;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && pp_en == '0 && hot_ones == '0)); // R1
    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !bad_ext); // R4
    AST_LOW_DIGITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !bad_low); // R5
    AST_IDLE_ROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !bad_zero); // R6
    AST_CORR_SET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b_top >= 4'd6) |=> pp_en[N]); // R7
    AST_CORR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b_top <= 4'd4) |=> !pp_en[N]); // R7
    AST_CORR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pp_en[N]) |-> (pp[N][4*N-1:0] == '0)); // R7
    AST_HOT_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((hot_ones & ~pp_en[N-1:0]) == '0)); // R8

endmodule

bind sd_decimal_pp_gen sdpp_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .b_top     (b_bcd[4*N-1 -: 4]),
    .out_valid (out_valid),
    .pp        (pp),
    .pp_en     (pp_en),
    .hot_ones  (hot_ones)
);

// File: tb/sd_decimal_pp_gen_tb.sv
module sd_decimal_pp_gen_tb;

    localparam int N   = 3;
    localparam int W   = 2*N + 1;
    localparam longint MOD = 10_000_000;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic [4*N-1:0]          a_bcd = '0;
    logic [4*N-1:0]          b_bcd = '0;
    logic                    out_valid;
    logic [N:0][4*W-1:0]     pp;
    logic [N:0]              pp_en;
    logic [N-1:0]            hot_ones;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sd_decimal_pp_gen #(.N(N)) u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .a_bcd (a_bcd), .b_bcd (b_bcd), .out_valid (out_valid),
        .pp (pp), .pp_en (pp_en), .hot_ones (hot_ones)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint pow10(input int e);
        longint p = 1;
        for (int i = 0; i < e; i++) p = p * 10;
        return p;
    endfunction

    function automatic longint row_val(input logic [4*W-1:0] r);
        longint v = 0;
        for (int k = 0; k < W; k++)
            v += longint'(4*r[4*k+3] + 2*r[4*k+2] + 2*r[4*k+1] + r[4*k]) * pow10(k);
        return v;
    endfunction

    function automatic logic [4*N-1:0] to_bcd(input int v);
        logic [4*N-1:0] r;
        for (int i = 0; i < N; i++) r[4*i +: 4] = 4'((v / int'(pow10(i))) % 10);
        return r;
    endfunction

    task automatic apply(input int a, input int b);
        int     cy = 0;
        longint total = 0;
        longint ar;
        a_bcd    = to_bcd(a);
        b_bcd    = to_bcd(b);
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b1, "R1 valid latency", longint'(out_valid), 1);
        for (int i = 0; i < N; i++) begin
            int     d, m;
            bit     ng;
            longint er;
            d = (b / int'(pow10(i))) % 10 + cy;
            if (d > 5) begin ng = (d != 10); m = 10 - d; cy = 1; end
            else       begin ng = 1'b0;      m = d;      cy = 0; end
            if (m == 0)  er = 0;
            else if (ng) er = MOD - (longint'(m) * a + 1) * pow10(i);
            else         er = longint'(m) * a * pow10(i);
            ar = row_val(pp[i]);
            if (m == 0) chk(ar == er, "R6 zero row", ar, er);
            else        chk(ar == er, "R3 R5 row value", ar, er);
            chk(pp_en[i] == (m != 0), "R9 row enable", longint'(pp_en[i]), longint'(m != 0));
            chk(hot_ones[i] == ng, "R8 hot one", longint'(hot_ones[i]), longint'(ng));
            if (m != 0)
                chk(pp[i][4*W-1 -: 4] == (ng ? 4'b1111 : 4'b0000), "R4 top digit fill",
                    longint'(pp[i][4*W-1 -: 4]), ng ? 15 : 0);
            total += ar + (hot_ones[i] ? pow10(i) : 0);
        end
        ar = row_val(pp[N]);
        chk(pp_en[N] == cy[0], "R7 corrective enable", longint'(pp_en[N]), cy);
        chk(ar == (cy != 0 ? longint'(a) * pow10(N) : 0), "R7 corrective row", ar,
            cy != 0 ? longint'(a) * pow10(N) : 0);
        total += ar;
        chk(total % MOD == (longint'(a) * b) % MOD, "R2 product sum", total % MOD,
            (longint'(a) * b) % MOD);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int avals[20] = '{0, 1, 2, 5, 9, 10, 38, 64, 99, 123,
                          250, 333, 456, 500, 555, 707, 789, 888, 901, 999};
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset valid", longint'(out_valid), 0);
        chk(pp_en == '0 && hot_ones == '0, "R1 reset flags", longint'(pp_en), 0);
        chk(pp == '0, "R1 reset rows", row_val(pp[0]), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 idle after reset", longint'(out_valid), 0);

        foreach (avals[ai])
            for (int b = 0; b < 1000; b++)
                apply(avals[ai], b);

        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 drop valid", longint'(out_valid), 0);

        // reset in the middle of traffic
        apply(999, 999);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid === 1'b0 && pp_en == '0, "R1 mid reset", longint'(pp_en), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule